// File: doc/BRIEF.md
# Charger PWM and Cutoff Controller

This block drives the charge switch that connects a charger to a battery. It produces a pulse-width-modulated waveform whose base rate depends on the kind of charger attached. A standard charger runs at one thirty-second of the fast-charger rate, which matches a 1 Hz standard rate against a 32 Hz fast rate. The duty is an 8-bit setting that reaches both full off and full on. A new duty or charger type is picked up only when a PWM period starts, so no partial pulse ever reaches the switch.

Two analog comparators watch the battery voltage against an upper and a lower threshold, and a third reports the charge-current limit. A two-state hysteresis machine forces the switch off once the upper threshold is crossed. It lets charging resume only after the voltage has dropped below the lower threshold. The PWM keeps running throughout, and no other operating mode changes.

The block also registers an over-voltage flag, an over-current flag that software can mask, and a cutoff-limit code. The limit code selects the comparator threshold of 3.6 V, 5.0 V or 5.25 V, and 3.6 V is the reset default.

Top module: `chg_pwm_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, switch_o, pwm_o, ovv_o and ovc_o are 0, vlim_o is 0 (the 3.6 V code), and the hysteresis machine is in its RUN state.
- R2: One PWM period lasts 255 ticks. A tick is FAST_DIV clock cycles when the latched type is fast (fast_i=1) and 32*FAST_DIV cycles when it is standard (fast_i=0). The type latched at reset is standard.
- R3: With latched duty d, pwm_o is high for exactly d ticks of each period, starting at the period's first tick. A duty of 0 keeps pwm_o constantly low, and a duty of 255 keeps it constantly high.
- R4: Changes of duty_i or fast_i made in the middle of a period have no effect on pwm_o until the next period starts.
- R5: In state RUN, vbat_hi_i=1 causes the transition RUN->HOLD, and switch_o is 0 from the next cycle on. In HOLD, switch_o stays 0 whatever pwm_o does, and the PWM keeps running.
- R6: In state HOLD, vbat_lo_i=1 with vbat_hi_i=0 causes the transition HOLD->RUN, and switch_o equals pwm_o from the next cycle on. While vbat_hi_i=1 the machine stays in HOLD even if vbat_lo_i is also 1.
- R7: ovv_o equals the value that vbat_hi_i had one cycle earlier.
- R8: ovc_o equals ibat_lim_i AND ovc_en_i as they stood one cycle earlier. ovc_en_i=0 keeps ovc_o at 0.
- R9: vlim_o takes lim_sel_i one cycle later for codes 0 (3.6 V), 1 (5.0 V) and 2 (5.25 V). Code 3 is ignored and leaves vlim_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_i | input | 1 | Charger type: 1 fast, 0 standard |
| duty_i | input | DUTY_W | Requested duty, in ticks per 255-tick period |
| lim_sel_i | input | 2 | Requested cutoff-limit code |
| ovc_en_i | input | 1 | Enable for the over-current flag |
| vbat_hi_i | input | 1 | Comparator: battery above upper threshold |
| vbat_lo_i | input | 1 | Comparator: battery below lower threshold |
| ibat_lim_i | input | 1 | Comparator: charge current at its limit |
| switch_o | output | 1 | Charge-switch drive |
| pwm_o | output | 1 | Raw PWM waveform |
| ovv_o | output | 1 | Over-voltage flag |
| ovc_o | output | 1 | Over-current flag |
| vlim_o | output | 2 | Active cutoff-limit code |

## Verification
Two events can land in the same clock edge: the start of a PWM period, which raises pwm_o, and entry into HOLD, which must suppress switch_o. The bench locates a period start from a rising edge of pwm_o at duty 128 in fast mode. It then counts 254 cycles and raises vbat_hi_i so that the comparator is registered on the very edge that starts the next period. It judges the result by requiring pwm_o high, switch_o low and ovv_o high on the following sample.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic {
        CUT_RUN  = 1'b0,
        CUT_HOLD = 1'b1
    } cut_state_t;

    typedef enum logic [1:0] {
        LIM_3V60 = 2'd0,
        LIM_5V00 = 2'd1,
        LIM_5V25 = 2'd2,
        LIM_RSVD = 2'd3
    } lim_code_t;

endpackage

// File: rtl/chg_tick.sv
module chg_tick #(
    parameter int FAST_DIV = 2,
    parameter int STD_MULT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_q,
    output logic tick_o
);
    localparam int STD_DIV = FAST_DIV * STD_MULT;
    localparam int CW      = $clog2(STD_DIV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;

    assign last_cnt = fast_q ? CW'(FAST_DIV - 1) : CW'(STD_DIV - 1);
    assign tick_o   = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/chg_pwm.sv
module chg_pwm #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              fast_i,
    output logic              fast_q_o,
    output logic              pwm_o
);
    localparam int STEPS = (1 << DUTY_W) - 1;

    logic [DUTY_W-1:0] step_q;
    logic [DUTY_W-1:0] duty_q;
    logic              wrap;

    assign wrap  = tick_i && (step_q == DUTY_W'(STEPS - 1));
    assign pwm_o = (step_q < duty_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            duty_q   <= '0;
            fast_q_o <= 1'b0;
        end else if (wrap) begin
            step_q   <= '0;
            duty_q   <= duty_i;
            fast_q_o <= fast_i;
        end else if (tick_i) begin
            step_q   <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/chg_cutoff.sv
module chg_cutoff
    import chg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vbat_hi_i,
    input  logic vbat_lo_i,
    output logic hold_o
);
    cut_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CUT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CUT_RUN:  if (vbat_hi_i)               state_d = CUT_HOLD;
            CUT_HOLD: if (vbat_lo_i && !vbat_hi_i) state_d = CUT_RUN;
            default:                               state_d = CUT_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CUT_RUN:  hold_o = 1'b0;
            CUT_HOLD: hold_o = 1'b1;
            default:  hold_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/chg_pwm_ctrl.sv
module chg_pwm_ctrl
    import chg_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int STD_MULT = 32,
    parameter int DUTY_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [1:0]        lim_sel_i,
    input  logic              ovc_en_i,
    input  logic              vbat_hi_i,
    input  logic              vbat_lo_i,
    input  logic              ibat_lim_i,
    output logic              switch_o,
    output logic              pwm_o,
    output logic              ovv_o,
    output logic              ovc_o,
    output logic [1:0]        vlim_o
);
    logic tick;
    logic fast_q;
    logic hold;

    chg_tick #(.FAST_DIV(FAST_DIV), .STD_MULT(STD_MULT)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .fast_q (fast_q),
        .tick_o (tick)
    );

    chg_pwm #(.DUTY_W(DUTY_W)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .duty_i   (duty_i),
        .fast_i   (fast_i),
        .fast_q_o (fast_q),
        .pwm_o    (pwm_o)
    );

    chg_cutoff u_cut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vbat_hi_i (vbat_hi_i),
        .vbat_lo_i (vbat_lo_i),
        .hold_o    (hold)
    );

    assign switch_o = pwm_o & ~hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovv_o  <= 1'b0;
            ovc_o  <= 1'b0;
            vlim_o <= LIM_3V60;
        end else begin
            ovv_o <= vbat_hi_i;
            ovc_o <= ibat_lim_i & ovc_en_i;
            if (lim_sel_i != LIM_RSVD) vlim_o <= lim_sel_i;
        end
    end
endmodule

// File: rtl/chg_pwm_ctrl_chk.sv
module chg_pwm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vbat_hi_i,
    input logic       vbat_lo_i,
    input logic       ibat_lim_i,
    input logic       ovc_en_i,
    input logic       pwm_o,
    input logic       switch_o,
    input logic       ovv_o,
    input logic       ovc_o,
    input logic [1:0] vlim_o
);
    AST_CUTOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        vbat_hi_i |=> !switch_o); // R5
    AST_SWITCH_NEEDS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |-> pwm_o); // R5
    AST_RESUME_FOLLOWS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (vbat_lo_i && !vbat_hi_i) |=> (switch_o == pwm_o)); // R6
    AST_OVV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ovv_o == $past(vbat_hi_i)); // R7
    AST_OVC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ovc_en_i |=> !ovc_o); // R8
    AST_OVC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_en_i && ibat_lim_i) |=> ovc_o); // R8
    AST_LIM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vlim_o != 2'd3); // R9
endmodule

bind chg_pwm_ctrl chg_pwm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vbat_hi_i  (vbat_hi_i),
    .vbat_lo_i  (vbat_lo_i),
    .ibat_lim_i (ibat_lim_i),
    .ovc_en_i   (ovc_en_i),
    .pwm_o      (pwm_o),
    .switch_o   (switch_o),
    .ovv_o      (ovv_o),
    .ovc_o      (ovc_o),
    .vlim_o     (vlim_o)
);

// File: tb/sim_chg_pwm_ctrl.sv
module sim_chg_pwm_ctrl;
    localparam int FDIV  = 1;
    localparam int SMUL  = 32;
    localparam int PFAST = 255 * FDIV;
    localparam int PSTD  = 255 * FDIV * SMUL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_i = 1'b1;
    logic [7:0] duty_i = 8'd0;
    logic [1:0] lim_sel_i = 2'd0;
    logic       ovc_en_i = 1'b0;
    logic       vbat_hi_i = 1'b0;
    logic       vbat_lo_i = 1'b0;
    logic       ibat_lim_i = 1'b0;
    logic       switch_o, pwm_o, ovv_o, ovc_o;
    logic [1:0] vlim_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chg_pwm_ctrl #(.FAST_DIV(FDIV), .STD_MULT(SMUL), .DUTY_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .fast_i(fast_i), .duty_i(duty_i),
        .lim_sel_i(lim_sel_i), .ovc_en_i(ovc_en_i), .vbat_hi_i(vbat_hi_i),
        .vbat_lo_i(vbat_lo_i), .ibat_lim_i(ibat_lim_i), .switch_o(switch_o),
        .pwm_o(pwm_o), .ovv_o(ovv_o), .ovc_o(ovc_o), .vlim_o(vlim_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic count_high(input int len, output int highs);
        highs = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            highs += int'(pwm_o);
        end
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        prev = pwm_o;
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            n++;
            if (!prev && pwm_o) break;
            prev = pwm_o;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin : main
        int h, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 switch in reset", int'(switch_o), 0);
        chk("R1 pwm in reset", int'(pwm_o), 0);
        chk("R1 ovv/ovc in reset", int'(ovv_o) + int'(ovc_o), 0);
        chk("R1 vlim in reset", int'(vlim_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm after reset", int'(pwm_o), 0);

        // R3 duty 0 over the first (standard) period
        count_high(PSTD + 40, h);
        chk("R3 duty 0 constant low", h, 0);

        // R2/R3 fast sweep, high count over one whole period
        for (int d = 0; d < 258; d += 15) begin
            duty_i = (d > 255) ? 8'd1 : 8'(d);
            repeat (PFAST + 1) @(negedge clk);
            count_high(PFAST, h);
            chk($sformatf("R3 fast duty %0d", duty_i), h, int'(duty_i) * FDIV);
        end
        duty_i = 8'd254;
        repeat (PFAST + 1) @(negedge clk);
        count_high(PFAST, h);
        chk("R3 fast duty 254", h, 254 * FDIV);

        // R2 fast period, rise to rise
        duty_i = 8'd128;
        repeat (PFAST + 1) @(negedge clk);
        wait_rise(n);
        wait_rise(n);
        chk("R2 fast period", n, PFAST);

        // R4 mid-period change ignored until boundary
        duty_i = 8'd200;
        repeat (PFAST + 1) @(negedge clk);
        wait_rise(n);
        duty_i = 8'd20;
        fast_i = 1'b0;
        repeat (100) @(negedge clk);
        chk("R4 old duty holds mid-period", int'(pwm_o), 1);
        repeat (54) @(negedge clk);
        chk("R4 old type holds mid-period", int'(pwm_o), 1);
        fast_i = 1'b1;
        repeat (PFAST + 1) @(negedge clk);
        count_high(PFAST, h);
        chk("R4 new duty after boundary", h, 20 * FDIV);

        // R5/R6/R7 hysteresis with pwm constant high
        duty_i = 8'd255;
        repeat (PFAST + 1) @(negedge clk);
        chk("R3 duty 255 high", int'(switch_o), 1);
        vbat_hi_i = 1'b1;
        @(negedge clk);
        chk("R5 switch off after hi", int'(switch_o), 0);
        chk("R7 ovv set", int'(ovv_o), 1);
        chk("R5 pwm keeps running", int'(pwm_o), 1);
        vbat_hi_i = 1'b0;
        repeat (50) @(negedge clk);
        chk("R5 hold persists", int'(switch_o), 0);
        chk("R7 ovv clears", int'(ovv_o), 0);
        vbat_hi_i = 1'b1;
        vbat_lo_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 hi has priority over lo", int'(switch_o), 0);
        vbat_hi_i = 1'b0;
        @(negedge clk);
        chk("R6 resume after lo", int'(switch_o), 1);
        vbat_lo_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 stays resumed", int'(switch_o), 1);

        // R5 cutoff entry on the same edge that starts a period
        duty_i = 8'd128;
        repeat (PFAST + 1) @(negedge clk);
        wait_rise(n);
        repeat (254) @(negedge clk);
        chk("R5 pwm low at step 254", int'(pwm_o), 0);
        vbat_hi_i = 1'b1;
        @(negedge clk);
        chk("R5 coincide pwm high", int'(pwm_o), 1);
        chk("R5 coincide switch low", int'(switch_o), 0);
        chk("R7 coincide ovv", int'(ovv_o), 1);
        vbat_hi_i = 1'b0;
        vbat_lo_i = 1'b1;
        @(negedge clk);
        vbat_lo_i = 1'b0;
        chk("R6 switch follows pwm", int'(switch_o), int'(pwm_o));

        // R8 over-current flag and mask
        ibat_lim_i = 1'b1;
        @(negedge clk);
        chk("R8 masked", int'(ovc_o), 0);
        ovc_en_i = 1'b1;
        @(negedge clk);
        chk("R8 enabled", int'(ovc_o), 1);
        ibat_lim_i = 1'b0;
        @(negedge clk);
        chk("R8 clears", int'(ovc_o), 0);

        // R9 limit code
        lim_sel_i = 2'd1;
        @(negedge clk);
        chk("R9 code 1", int'(vlim_o), 1);
        lim_sel_i = 2'd3;
        repeat (2) @(negedge clk);
        chk("R9 code 3 ignored", int'(vlim_o), 1);
        lim_sel_i = 2'd2;
        @(negedge clk);
        chk("R9 code 2", int'(vlim_o), 2);
        lim_sel_i = 2'd0;
        @(negedge clk);
        chk("R9 code 0", int'(vlim_o), 0);

        // R2/R3 standard charger
        fast_i = 1'b0;
        duty_i = 8'd100;
        repeat (PFAST + 1) @(negedge clk);
        count_high(PSTD, h);
        chk("R3 std duty 100", h, 100 * FDIV * SMUL);
        wait_rise(n);
        wait_rise(n);
        chk("R2 std period", n, PSTD);
        duty_i = 8'd255;
        repeat (PSTD + 1) @(negedge clk);
        count_high(PSTD, h);
        chk("R3 std duty 255", h, PSTD);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule